// File: doc/BRIEF.md
# T1 Framing-Bit Link Inserter

This block builds the outgoing T1 bit stream from two serial inputs: the payload stream and a slow link-data stream. An external timing generator supplies the frame number and the bit position within the frame. At the positions that the framing mode selects, the link bit takes the place of the payload bit. Those positions are the framing bit of even frames for the 12-frame superframe, the framing bit of odd frames for the 24-frame extended superframe, or one bit of channel 24 in data-link mode. Every other bit passes through unchanged.

The merged stream passes through a fixed delay line and then an output encoder. The encoder drives two rails, either as dual-unipolar alternate-mark-inversion or as NRZ on the positive rail with the negative rail held low. The latency from either input to the rails is constant, so a framer upstream can plan its timing around a fixed offset. Generating the framing pattern and computing the CRC are left to other blocks.

Top module: `t1_link_inserter`

## Requirements
- R1: While `rst_n` is low, and after it is released, both rails are low. The first mark after reset goes out on `pos_out`.
- R2: A bit presented in cycle c (captured at the clock edge that ends cycle c) appears on the rails during cycle c+10.
- R3: With `mode`=0 (12-frame superframe) and `link_en`=1, the bit at `bit_pos`=0 of every even `frame_num` is taken from `link_in`. With both `link_en` and `strap_en` low, that bit is taken from `ser_in`.
- R4: With `mode`=0, `strap_en`=1 enables the same even-frame insertion when `link_en` is 0.
- R5: With `mode`=1 (24-frame extended superframe), the bit at `bit_pos`=0 of every odd `frame_num` is taken from `link_in`, whatever the values of `link_en` and `strap_en`.
- R6: With `mode`=2 (data link), bit 7 of channel 24 is taken from `link_in` in every frame. Channel 24 occupies `bit_pos` 185 to 192, with bit k (k=1 is the MSB) at position 184+k, so bit 7 is `bit_pos`=191.
- R7: Every other position takes `ser_in`, and `link_in` has no effect on it. `mode`=3 inserts nothing.
- R8: With `nrz_sel`=0, each 1 is sent as a mark on one rail, alternating between `pos_out` and `neg_out`. Each 0 drives both rails low. The two rails are never high together.
- R9: With `nrz_sel`=1, `pos_out` carries the data bit and `neg_out` is low. The alternation state does not advance while NRZ is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; rails update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial payload bit |
| link_in | input | 1 | Serial link-data bit |
| frame_num | input | 5 | Frame number, 1 to 24 |
| bit_pos | input | 8 | Bit position in the frame: 0 is the framing bit, 1 to 192 are payload |
| mode | input | 2 | 0 superframe, 1 extended superframe, 2 channel-24 data link, 3 no insertion |
| link_en | input | 1 | Control enable for superframe link insertion |
| strap_en | input | 1 | Hardware strap that enables superframe link insertion |
| nrz_sel | input | 1 | 0 dual-unipolar AMI, 1 NRZ on the positive rail |
| pos_out | output | 1 | Positive rail |
| neg_out | output | 1 | Negative rail |

## Verification
For every cycle, the bench stores the bit that the requirements predict from the inputs of that cycle. It compares that bit against the rails exactly ten iterations later, so an error in the latency shows up as a mismatch. The rail format is judged against `nrz_sel` as captured one edge before the rails are sampled, because the encoder applies it at its own output register. All input changes happen on the falling edge, and the rails are read on the falling edge before the next inputs are driven.

// File: rtl/t1_link_inserter.sv
module t1_link_inserter #(
  parameter int LATENCY = 10,
  parameter int DL_BIT  = 191
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  input  logic       link_in,
  input  logic [4:0] frame_num,
  input  logic [7:0] bit_pos,
  input  logic [1:0] mode,
  input  logic       link_en,
  input  logic       strap_en,
  input  logic       nrz_sel,
  output logic       pos_out,
  output logic       neg_out
);
  localparam int DEPTH = LATENCY - 1;
  localparam logic [7:0] DL_POS = 8'(DL_BIT);

  logic fbit, ins, merged, mark, pol_neg;
  logic [DEPTH-1:0] dly;

  assign fbit = (bit_pos == 8'd0);
  assign ins  = (mode == 2'd0 && fbit && !frame_num[0] && (link_en || strap_en))
             || (mode == 2'd1 && fbit && frame_num[0])
             || (mode == 2'd2 && bit_pos == DL_POS);
  assign merged = ins ? link_in : ser_in;
  assign mark   = dly[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) dly <= '0;
    else        dly <= {dly[DEPTH-2:0], merged};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_out <= 1'b0;
      neg_out <= 1'b0;
      pol_neg <= 1'b0;
    end else if (nrz_sel) begin
      pos_out <= mark;
      neg_out <= 1'b0;
    end else begin
      pos_out <= mark & ~pol_neg;
      neg_out <= mark & pol_neg;
      if (mark) pol_neg <= ~pol_neg;
    end
  end

  assert_rails_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_out && neg_out));

  assert_nrz_neg_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nrz_sel |=> !neg_out);

  assert_ami_alternate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!nrz_sel && mark) |=> (pos_out != $past(pol_neg)) && (pol_neg != $past(pol_neg)));

  assert_tail_to_rail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!nrz_sel && !mark) |=> !pos_out && !neg_out);

  assert_sf_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && fbit && !frame_num[0] && (link_en || strap_en)) |=> dly[0] == $past(link_in));

  assert_esf_insert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && fbit && frame_num[0]) |=> dly[0] == $past(link_in));

  assert_dl_insert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && bit_pos == DL_POS) |=> dly[0] == $past(link_in));

  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |=> dly[0] == $past(ser_in));
endmodule

// File: tb/test_t1_link_inserter.sv
module test_t1_link_inserter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_in = 0, link_in = 0, link_en = 0, strap_en = 0, nrz_sel = 0;
  logic [4:0] frame_num = 5'd1;
  logic [7:0] bit_pos = 8'd0;
  logic [1:0] mode = 2'd0;
  logic pos_out, neg_out;

  int compared = 0, mismatched = 0;
  bit done = 0;

  t1_link_inserter i_t1_link_inserter (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .link_in(link_in),
    .frame_num(frame_num), .bit_pos(bit_pos), .mode(mode),
    .link_en(link_en), .strap_en(strap_en), .nrz_sel(nrz_sel),
    .pos_out(pos_out), .neg_out(neg_out));

  always #2 clk = ~clk;

  function automatic string tag(int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(int r, logic ap, logic an, logic ep, logic en);
    compared++;
    if (ap !== ep || an !== en) begin
      mismatched++;
      $display("FAIL %s: rails pos=%b neg=%b expected pos=%b neg=%b at %0t",
               tag(r), ap, an, ep, en, $time);
    end
  endtask

  logic exp_bit [16];
  int   exp_req [16];
  logic pol = 0;
  logic [31:0] rs = 32'h1234_5678;

  function automatic logic [31:0] xs(logic [31:0] v);
    logic [31:0] x = v;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    #1_200_000;
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int t = 0;
    int f = 1, b = 0;
    for (int i = 0; i < 16; i++) begin exp_bit[i] = 0; exp_req[i] = 2; end
    repeat (4) @(negedge clk);
    check(1, pos_out, neg_out, 0, 0);        // R1 rails low in reset
    rst_n = 1'b1;
    for (int c = 0; c < 10; c++) begin
      int md, le, se;
      case (c)
        0: begin md = 0; le = 0; se = 0; end
        1: begin md = 0; le = 1; se = 0; end
        2: begin md = 0; le = 0; se = 1; end
        3: begin md = 0; le = 1; se = 1; end
        4: begin md = 1; le = 0; se = 0; end
        5: begin md = 1; le = 1; se = 1; end
        6: begin md = 2; le = 0; se = 0; end
        7: begin md = 2; le = 1; se = 1; end
        8: begin md = 3; le = 1; se = 1; end
        default: begin md = 0; le = 1; se = 0; end
      endcase
      for (int n = 0; n < 24 * 193; n++) begin
        logic e, sv, lv, hit;
        int r, k;
        @(negedge clk);
        // R2: bit of iteration t is due on the rails at iteration t+10
        k = (t + 6) % 16;
        e = (t >= 10) ? exp_bit[k] : 1'b0;
        r = (t >= 10) ? exp_req[k] : 1;
        if (nrz_sel) check(e ? 9 : r, pos_out, neg_out, e, 0);
        else begin
          check(e ? 8 : r, pos_out, neg_out, e & ~pol, e & pol);
          if (e) pol = ~pol;
        end
        rs = xs(rs); sv = rs[3]; lv = rs[17];
        mode = 2'(md); link_en = 1'(le); strap_en = 1'(se);
        nrz_sel = (c % 2 == 1);
        frame_num = 5'(f); bit_pos = 8'(b);
        ser_in = sv; link_in = lv;
        hit = 0; r = 7;
        if (md == 0 && b == 0 && f % 2 == 0) begin
          r = (le == 0 && se == 1) ? 4 : 3;
          hit = (le == 1 || se == 1);
        end else if (md == 1 && b == 0 && f % 2 == 1) begin r = 5; hit = 1; end
        else if (md == 2 && b == 191) begin r = 6; hit = 1; end
        exp_bit[t % 16] = hit ? lv : sv;
        exp_req[t % 16] = r;
        t++;
        b++;
        if (b == 193) begin b = 0; f = (f == 24) ? 1 : f + 1; end
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule